// File: doc/BRIEF.md
# Gated timestamp clock and sequencer

This block makes a timestamp tick for a data acquisition system and keeps a local timestamp count from it. The tick normally comes from the system clock divided by a fixed ratio. The default ratio is four, which turns 40 MHz into 10 MHz. An external reference clock can be selected in its place. That reference is brought into the system clock domain through a two-flop synchroniser, and each of its rising edges gives one tick. A veto input suppresses ticks for as long as it is held. A suppressed tick is lost and is not delivered later.

The gated tick is driven out on a port so that other timestamp counters in the system can count in step. Inside the block it advances a wide counter. The counter wraps to zero without stopping and sets a sticky overflow flag when it does. Software can clear the counter and the flag at any time.

A run-start sequencer prepares each run in a fixed order. It clears the timestamp counter and then strobes a clear for the trigger register. It then waits for the "all modules initialised" indication. After that it waits a programmable number of system clock cycles before it raises run-enable. A run-end request returns the sequencer to idle from any state. The counter keeps its value after a run-end request.

Top module: `ts_clock_seq`

## Requirements
- R1: When `ext_sel` is 0 and `veto` is low, `tick_out` is high for exactly one cycle in every DIV system clock cycles (DIV defaults to 4).
- R2: When `ext_sel` is 1, `tick_out` gives exactly one single-cycle pulse for each rising edge of `ext_clk`. The pulse appears in the cycle after the third rising system clock edge that follows the rising edge of `ext_clk`.
- R3: If `veto` is high at a clock edge, `tick_out` is low in the cycle that follows that edge. A tick suppressed this way is dropped and is never delivered later.
- R4: `ts_value` increases by exactly one at each clock edge where `tick_out` is high and no clear is active. It does not change at any other edge.
- R5: `sw_clear` high at an edge sets `ts_value` to 0 and `ts_overflow` to 0 at that edge. This holds even when `tick_out` is high at the same edge, so clear takes priority over counting.
- R6: A tick that arrives while `ts_value` is all ones wraps the count to 0 and sets `ts_overflow`. `ts_overflow` then stays set until the next clear.
- R7: `run_start` sampled in idle starts the sequence. At the next edge the counter is cleared, and `ts_value` reads 0 in the cycle where `trig_clear` is high. `trig_clear` is high for exactly one cycle. After that the sequencer waits for `init_done`.
- R8: `delay_cycles` is sampled at the edge where `init_done` is seen in the wait state. `run_en` rises delay_cycles+1 edges after that edge, and this includes the case delay_cycles = 0.
- R9: `run_done` is a single-cycle pulse. It is high in the first cycle in which `run_en` is high.
- R10: `run_end` at any edge sends the sequencer to idle, and `run_en` is low in the next cycle. `run_end` takes priority over `run_start`, and it leaves the timestamp counter untouched.
- R11: After reset, `tick_out`, `ts_value`, `ts_overflow`, `trig_clear`, `run_en` and `run_done` are all 0, and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_sel | input | 1 | 1 selects the external reference as the tick source |
| ext_clk | input | 1 | External reference clock, asynchronous |
| veto | input | 1 | Suppresses ticks while high |
| sw_clear | input | 1 | Software clear of the counter and overflow flag |
| run_start | input | 1 | Starts the begin sequence |
| init_done | input | 1 | Indicates that all modules are initialised |
| run_end | input | 1 | Ends the run and returns the sequencer to idle |
| delay_cycles | input | DLY_W | Settling delay in system clock cycles |
| tick_out | output | 1 | Gated timestamp tick, shared with other counters |
| ts_value | output | TS_W | Local timestamp count |
| ts_overflow | output | 1 | Sticky wrap flag |
| trig_clear | output | 1 | One-cycle clear strobe for the trigger register |
| run_en | output | 1 | Run enable |
| run_done | output | 1 | Pulse marking entry to the run state |

## Verification
A software clear and a tick can land on the same clock edge. The bench provokes this by waiting for a cycle where `tick_out` is high and raising `sw_clear` in that same cycle. The result is judged by reading `ts_value` as 0, not 1, in the following cycle. A second collision is a run-end request and a run-start request arriving together in idle. The expected result is that `trig_clear` never pulses afterwards. A behavioural model in the bench predicts every output on every clock.

// File: rtl/ts_pkg.sv
package ts_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_CLR_TS    = 3'd1,
        SEQ_CLR_TRIG  = 3'd2,
        SEQ_WAIT_INIT = 3'd3,
        SEQ_DELAY     = 3'd4,
        SEQ_RUN       = 3'd5
    } seq_state_e;
endpackage

// File: rtl/ts_tick_gen.sv
module ts_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel,
    input  logic ext_clk,
    input  logic veto,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             s1;
        logic             s2;
        logic             s3;
        logic             tick;
    } tg_regs_t;

    tg_regs_t r_q, r_d;
    logic     int_tick;
    logic     ext_rise;

    always_comb begin
        r_d      = r_q;
        int_tick = (r_q.div == DIV_W'(DIV - 1));
        ext_rise = r_q.s2 & ~r_q.s3;
        r_d.div  = int_tick ? '0 : DIV_W'(r_q.div + 1'b1);
        r_d.s1   = ext_clk;
        r_d.s2   = r_q.s1;
        r_d.s3   = r_q.s2;
        r_d.tick = (ext_sel ? ext_rise : int_tick) & ~veto;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = r_q.tick;

    AST_VETO_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        veto |=> !tick); // R3
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
endmodule

// File: rtl/ts_counter.sv
module ts_counter #(
    parameter int TS_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    output logic [TS_W-1:0] value,
    output logic            ovf
);
    typedef struct packed {
        logic [TS_W-1:0] cnt;
        logic            ovf;
    } cnt_regs_t;

    cnt_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
            r_d.ovf = 1'b0;
        end else if (inc) begin
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == '1) r_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign value = r_q.cnt;
    assign ovf   = r_q.ovf;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0) && !ovf); // R5
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(value) && $stable(ovf)); // R4
    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && value != '1) |=> value == TS_W'($past(value) + 1'b1)); // R4
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && value == '1) |=> (value == '0) && ovf); // R6
endmodule

// File: rtl/ts_run_seq.sv
module ts_run_seq
    import ts_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_start,
    input  logic             init_done,
    input  logic             run_end,
    input  logic [DLY_W-1:0] delay_cycles,
    output logic             ts_clr,
    output logic             trig_clear,
    output logic             run_en,
    output logic             run_done
);
    typedef struct packed {
        seq_state_e       state;
        logic [DLY_W-1:0] dly;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (run_end) begin
            r_d.state = SEQ_IDLE;
        end else begin
            unique case (r_q.state)
                SEQ_IDLE:      if (run_start) r_d.state = SEQ_CLR_TS;
                SEQ_CLR_TS:    r_d.state = SEQ_CLR_TRIG;
                SEQ_CLR_TRIG:  r_d.state = SEQ_WAIT_INIT;
                SEQ_WAIT_INIT: if (init_done) begin
                    r_d.state = SEQ_DELAY;
                    r_d.dly   = delay_cycles;
                end
                SEQ_DELAY: begin
                    if (r_q.dly == '0) begin
                        r_d.state = SEQ_RUN;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.dly = r_q.dly - 1'b1;
                    end
                end
                SEQ_RUN:       r_d.state = SEQ_RUN;
                default:       r_d.state = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= SEQ_IDLE;
            r_q.dly   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ts_clr     = (r_q.state == SEQ_CLR_TS);
    assign trig_clear = (r_q.state == SEQ_CLR_TRIG);
    assign run_en     = (r_q.state == SEQ_RUN);
    assign run_done   = r_q.done;

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        run_end |=> !run_en && !trig_clear && !ts_clr); // R10
    AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_clr && !run_end) |=> trig_clear); // R7
    AST_TRIG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_clear |=> !trig_clear); // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done); // R9
    AST_DONE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> run_done); // R9
endmodule

// File: rtl/ts_clock_seq.sv
module ts_clock_seq #(
    parameter int DIV   = 4,
    parameter int TS_W  = 48,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic             ext_clk,
    input  logic             veto,
    input  logic             sw_clear,
    input  logic             run_start,
    input  logic             init_done,
    input  logic             run_end,
    input  logic [DLY_W-1:0] delay_cycles,
    output logic             tick_out,
    output logic [TS_W-1:0]  ts_value,
    output logic             ts_overflow,
    output logic             trig_clear,
    output logic             run_en,
    output logic             run_done
);
    logic seq_ts_clr;
    logic cnt_clr;

    ts_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_sel (ext_sel),
        .ext_clk (ext_clk),
        .veto    (veto),
        .tick    (tick_out)
    );

    assign cnt_clr = sw_clear | seq_ts_clr;

    ts_counter #(.TS_W(TS_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (tick_out),
        .value (ts_value),
        .ovf   (ts_overflow)
    );

    ts_run_seq #(.DLY_W(DLY_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_start    (run_start),
        .init_done    (init_done),
        .run_end      (run_end),
        .delay_cycles (delay_cycles),
        .ts_clr       (seq_ts_clr),
        .trig_clear   (trig_clear),
        .run_en       (run_en),
        .run_done     (run_done)
    );

    AST_NO_COUNT_WHEN_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clear && tick_out) |=> ts_value == '0); // R5
endmodule

// File: tb/sim_ts_clock_seq.sv
module sim_ts_clock_seq;
    localparam int DIV   = 4;
    localparam int TS_W  = 10;
    localparam int DLY_W = 16;
    localparam longint TS_MAX = (64'd1 << TS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_sel = 1'b0, ext_clk = 1'b0, veto = 1'b0, sw_clear = 1'b0;
    logic run_start = 1'b0, init_done = 1'b0, run_end = 1'b0;
    logic [DLY_W-1:0] delay_cycles = 16'd20;
    logic tick_out, ts_overflow, trig_clear, run_en, run_done;
    logic [TS_W-1:0] ts_value;

    int compared = 0;
    int mismatched = 0;
    bit live = 1'b0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    ts_clock_seq #(.DIV(DIV), .TS_W(TS_W), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_clk(ext_clk),
        .veto(veto), .sw_clear(sw_clear), .run_start(run_start),
        .init_done(init_done), .run_end(run_end), .delay_cycles(delay_cycles),
        .tick_out(tick_out), .ts_value(ts_value), .ts_overflow(ts_overflow),
        .trig_clear(trig_clear), .run_en(run_en), .run_done(run_done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model: sequencer states 0 idle, 1 clear ts,
    // 2 clear trig, 3 wait init, 4 delay, 5 run.
    int     m_div = 0;
    bit     m_e1 = 0, m_e2 = 0, m_e3 = 0;
    bit     m_tick = 0, m_ovf = 0, m_done = 0;
    longint m_cnt = 0;
    int     m_st = 0;
    int     m_dly = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_e1 = 0; m_e2 = 0; m_e3 = 0;
            m_tick = 0; m_ovf = 0; m_done = 0; m_cnt = 0; m_st = 0; m_dly = 0;
        end else begin
            bit src, n_tick, clr;
            int n_st, n_dly;
            bit n_done;
            src    = ext_sel ? (m_e2 && !m_e3) : (m_div == DIV - 1);
            n_tick = src && !veto;
            clr    = sw_clear || (m_st == 1);
            if (clr) begin
                m_cnt = 0; m_ovf = 0;
            end else if (m_tick) begin
                if (m_cnt == TS_MAX) begin m_cnt = 0; m_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            n_st = m_st; n_dly = m_dly; n_done = 0;
            if (run_end) n_st = 0;
            else begin
                case (m_st)
                    0: if (run_start) n_st = 1;
                    1: n_st = 2;
                    2: n_st = 3;
                    3: if (init_done) begin n_st = 4; n_dly = int'(delay_cycles); end
                    4: if (m_dly == 0) begin n_st = 5; n_done = 1; end
                       else n_dly = m_dly - 1;
                    default: n_st = m_st;
                endcase
            end
            m_st = n_st; m_dly = n_dly; m_done = n_done;
            m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            m_e3 = m_e2; m_e2 = m_e1; m_e1 = ext_clk;
            m_tick = n_tick;
        end
    end

    always @(negedge clk) begin
        if (live) begin
            chk(tick_out == m_tick, "R1 R2 R3 tick_out", tick_out, m_tick);
            chk(ts_value == m_cnt[TS_W-1:0], "R4 R5 R6 ts_value", ts_value, m_cnt);
            chk(ts_overflow == m_ovf, "R6 ts_overflow", ts_overflow, m_ovf);
            chk(trig_clear == (m_st == 2), "R7 trig_clear", trig_clear, m_st == 2);
            chk(run_en == (m_st == 5), "R8 R10 run_en", run_en, m_st == 5);
            chk(run_done == m_done, "R9 run_done", run_done, m_done);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int cnt;
        longint v;
        step(5);
        // R11: reset state
        chk(!tick_out && ts_value == 0 && !ts_overflow && !trig_clear && !run_en && !run_done,
            "R11 reset outputs", {tick_out, ts_overflow, trig_clear, run_en, run_done}, 0);
        rst_n = 1'b1;
        step(1);
        live = 1'b1;

        // R1: internal divider rate
        step(8);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin step(1); if (tick_out) cnt++; end
        chk(cnt == 10, "R1 ticks in 40 cycles", cnt, 10);

        // R3: veto suppresses ticks
        veto = 1'b1;
        step(1);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin step(1); if (tick_out) cnt++; end
        chk(cnt == 0, "R3 ticks under veto", cnt, 0);
        veto = 1'b0;
        step(6);

        // R2: external reference
        ext_sel = 1'b1;
        step(4);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            ext_clk = 1'b1;
            for (int k = 0; k < 5; k++) begin step(1); if (tick_out) cnt++; end
            ext_clk = 1'b0;
            for (int k = 0; k < 5; k++) begin step(1); if (tick_out) cnt++; end
        end
        chk(cnt == 10, "R2 ticks per external edge", cnt, 10);
        ext_sel = 1'b0;
        step(8);

        // R5: software clear collides with a tick
        for (int i = 0; i < 10 && !tick_out; i++) step(1);
        chk(tick_out == 1'b1, "R5 tick found for collision", tick_out, 1);
        sw_clear = 1'b1;
        step(1);
        sw_clear = 1'b0;
        chk(ts_value == 0 && !ts_overflow, "R5 clear beats tick", ts_value, 0);

        // R7: begin sequence order
        step(12);
        run_start = 1'b1;
        step(1);
        run_start = 1'b0;
        step(1);
        chk(trig_clear == 1'b1, "R7 trig_clear strobe", trig_clear, 1);
        chk(ts_value == 0, "R7 counter cleared first", ts_value, 0);
        step(1);
        chk(trig_clear == 1'b0, "R7 trig_clear one cycle", trig_clear, 0);
        step(10);
        chk(run_en == 1'b0, "R8 waits for init_done", run_en, 0);

        // R8, R9: settling delay of 20
        init_done = 1'b1;
        cnt = 0;
        for (int k = 0; k <= 20; k++) begin
            step(1);
            init_done = 1'b0;
            if (run_en) cnt++;
        end
        chk(cnt == 0, "R8 run_en early", cnt, 0);
        step(1);
        chk(run_en == 1'b1, "R8 run_en after delay", run_en, 1);
        chk(run_done == 1'b1, "R9 run_done with run_en", run_done, 1);
        step(1);
        chk(run_done == 1'b0 && run_en, "R9 run_done one cycle", run_done, 0);

        // R10: run end from RUN
        step(30);
        v = ts_value;
        run_end = 1'b1;
        step(1);
        run_end = 1'b0;
        chk(run_en == 1'b0, "R10 run_en drops", run_en, 0);
        chk(ts_value >= v, "R10 counter kept", ts_value, v);

        // R10: run end during the delay
        run_start = 1'b1; step(1); run_start = 1'b0; step(2);
        init_done = 1'b1; step(1); init_done = 1'b0;
        step(5);
        run_end = 1'b1; step(1); run_end = 1'b0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin step(1); if (run_en) cnt++; end
        chk(cnt == 0, "R10 abort during delay", cnt, 0);

        // R10: run_end wins over run_start in idle
        run_start = 1'b1; run_end = 1'b1; step(1); run_start = 1'b0; run_end = 1'b0;
        cnt = 0;
        for (int i = 0; i < 4; i++) begin step(1); if (trig_clear) cnt++; end
        chk(cnt == 0, "R10 end beats start", cnt, 0);

        // R8: zero delay
        delay_cycles = '0;
        run_start = 1'b1; step(1); run_start = 1'b0; step(2);
        init_done = 1'b1; step(1); init_done = 1'b0;
        chk(run_en == 1'b0, "R8 zero delay edge0", run_en, 0);
        step(1);
        chk(run_en == 1'b1 && run_done, "R8 zero delay run", run_en, 1);
        run_end = 1'b1; step(1); run_end = 1'b0;

        // R6: wrap and sticky overflow
        sw_clear = 1'b1; step(1); sw_clear = 1'b0;
        for (int i = 0; i < 6000 && ts_value != TS_W'(TS_MAX); i++) step(1);
        chk(ts_value == TS_W'(TS_MAX) && !ts_overflow, "R6 at max", ts_value, TS_MAX);
        for (int i = 0; i < 10 && ts_value == TS_W'(TS_MAX); i++) step(1);
        chk(ts_value == 0 && ts_overflow, "R6 wrap sets flag", ts_overflow, 1);
        step(20);
        chk(ts_overflow == 1'b1, "R6 flag sticky", ts_overflow, 1);
        sw_clear = 1'b1; step(1); sw_clear = 1'b0;
        chk(ts_overflow == 1'b0 && ts_value == 0, "R5 clear drops flag", ts_overflow, 0);
        step(5);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule